// File: doc/BRIEF.md
# Lockable Four-Way Instruction Cache Tag Controller

This block holds the tags and valid bits of a four-way set-associative instruction cache whose lines are never modified. A fetch address presented on the lookup port is split into offset, set index and tag. One cycle after the lookup is accepted, the block reports whether a valid line matched and in which way. On a miss it picks a way to receive the line, reports that way, and waits for the fill engine to signal completion. Only then are the tag and valid bit of that way written.

A four-bit lock mask, one bit per way, keeps ways out of the choice of a receiving way without stopping them from hitting. With every way locked, a miss allocates nothing and the fetch is left to be served from memory. Invalidation clears valid bits only, since no line can be dirty. It comes in three forms: by address (only if the line is present), by explicit set and way, or of the whole cache. The whole-cache form walks one set per cycle while `busy` is high.

Top module: `icache_tag_ctrl`

## Requirements
- R1: An address maps to set `addr[10:5]` and tag `addr[31:11]`, and bits `[4:0]` are ignored. A lookup is accepted on a clock edge where `lk_req` and `lk_ready` are both high. `rsp_valid` is high in the following cycle only, with `rsp_hit`=1 and `rsp_way` set to the way if a valid line of that set holds the tag.
- R2: A miss that allocates reports `rsp_hit`=0, `rsp_alloc`=1 and the chosen way in `rsp_way`. `lk_ready` and `inv_ready` stay low until a cycle with `fill_done` high. After that cycle the chosen way holds the line as valid.
- R3: When the set has invalid ways whose lock bit is clear, the receiving way is the lowest-numbered of them.
- R4: When every unlocked way of the set is valid, the receiving way is the first unlocked way found going upward, with wrap, from a per-set pointer. The pointer starts at 0 after reset and becomes the chosen way plus one (mod 4) after every allocation.
- R5: Bit n of `lock_mask` set means way n is never chosen to receive a line. Lines already in a locked way keep hitting.
- R6: With `lock_mask` = 4'b1111, a miss reports `rsp_alloc`=0 and `rsp_hit`=0. No tag, valid bit or pointer changes, and `lk_ready` is high again in the next cycle.
- R7: `inv_kind`=2'b00 clears the valid bit of the line holding `inv_addr` if it is present. If that address is absent, every line is left as it was.
- R8: `inv_kind`=2'b01 clears the valid bit of way `inv_way` in set `inv_set`.
- R9: `inv_kind`=2'b10 raises `busy` for exactly 64 cycles, starting in the cycle after acceptance. `lk_ready` and `inv_ready` are low throughout, and every line is invalid afterwards. `inv_kind`=2'b11 changes nothing.
- R10: The lock mask is sampled when a miss is accepted. Changing it while a fill is outstanding does not move that fill to another way.
- R11: After reset, `busy` and `rsp_valid` are low, `lk_ready` and `inv_ready` are high, and every line is invalid.
- R12: An invalidate command is accepted when the block is idle and `inv_req` is high. While `inv_req` is high, `lk_ready` is low, so invalidation wins over a lookup in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 32 | Fetch address to look up |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Result is a hit |
| rsp_alloc | output | 1 | Miss was given a way to fill |
| rsp_way | output | 2 | Hit way or receiving way |
| fill_done | input | 1 | Outstanding line fill has completed |
| lock_mask | input | 4 | Per-way lock bits, bit n for way n |
| inv_req | input | 1 | Invalidate command request |
| inv_kind | input | 2 | 00 address, 01 set/way, 10 whole cache, 11 none |
| inv_addr | input | 32 | Address for invalidate by address |
| inv_set | input | 6 | Set for invalidate by index |
| inv_way | input | 2 | Way for invalidate by index |
| inv_ready | output | 1 | Invalidate command can be accepted |
| busy | output | 1 | Whole-cache invalidation in progress |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 32-byte lines and 64 sets. With these values the whole-cache walk is short enough to time cycle by cycle against the full count of 64. Filling all four ways of one set takes only four misses, which brings the round-robin pointer and its skipping of locked ways into reach at once. A sweep that places one line in every set also reaches the highest set index, where the whole-cache walk ends.

// File: rtl/icache_tag_ctrl.sv
module icache_tag_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int SETS       = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        lk_req,
  input  logic [ADDR_W-1:0]           lk_addr,
  output logic                        lk_ready,
  output logic                        rsp_valid,
  output logic                        rsp_hit,
  output logic                        rsp_alloc,
  output logic [1:0]                  rsp_way,
  input  logic                        fill_done,
  input  logic [3:0]                  lock_mask,
  input  logic                        inv_req,
  input  logic [1:0]                  inv_kind,
  input  logic [ADDR_W-1:0]           inv_addr,
  input  logic [$clog2(SETS)-1:0]     inv_set,
  input  logic [1:0]                  inv_way,
  output logic                        inv_ready,
  output logic                        busy
);
  localparam int WAYS  = 4;
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_WALK} state_t;
  state_t state;

  logic [TAG_W-1:0] tag_q [WAYS][SETS];
  logic [SETS-1:0]  vld_q [WAYS];
  logic [1:0]       rr_q  [SETS];

  logic [IDX_W-1:0] fill_idx, walk_idx;
  logic [TAG_W-1:0] fill_tag;
  logic [1:0]       fill_way;

  wire [IDX_W-1:0] lk_idx  = lk_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] lk_tag  = lk_addr[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0] iv_idx  = inv_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] iv_tag  = inv_addr[ADDR_W-1 -: TAG_W];

  logic [WAYS-1:0] lk_vld, lk_hitv, iv_hitv;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign lk_vld[w]  = vld_q[w][lk_idx];
    assign lk_hitv[w] = vld_q[w][lk_idx] && (tag_q[w][lk_idx] == lk_tag);
    assign iv_hitv[w] = vld_q[w][iv_idx] && (tag_q[w][iv_idx] == iv_tag);
  end

  assign lk_ready  = (state == S_IDLE) && !inv_req;
  assign inv_ready = (state == S_IDLE);
  assign busy      = (state == S_WALK);

  wire lk_acc  = lk_req && lk_ready;
  wire inv_acc = inv_req && inv_ready;

  logic [1:0]      hit_way, vic, cand;
  logic            vic_ok;
  logic [WAYS-1:0] free;

  always_comb begin
    hit_way = '0;
    for (int w = WAYS-1; w >= 0; w--)
      if (lk_hitv[w]) hit_way = 2'(w);
  end

  always_comb begin
    free   = ~lk_vld & ~lock_mask;
    vic    = '0;
    vic_ok = 1'b0;
    cand   = '0;
    if (|free) begin
      for (int w = WAYS-1; w >= 0; w--)
        if (free[w]) begin
          vic    = 2'(w);
          vic_ok = 1'b1;
        end
    end else begin
      for (int k = WAYS-1; k >= 0; k--) begin
        cand = rr_q[lk_idx] + 2'(k);
        if (!lock_mask[cand]) begin
          vic    = cand;
          vic_ok = 1'b1;
        end
      end
    end
  end

  wire lk_hit = |lk_hitv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_alloc <= 1'b0;
      rsp_way   <= '0;
      fill_idx  <= '0;
      fill_tag  <= '0;
      fill_way  <= '0;
      walk_idx  <= '0;
      for (int w = 0; w < WAYS; w++) vld_q[w] <= '0;
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else begin
      rsp_valid <= lk_acc;
      if (lk_acc) begin
        rsp_hit   <= lk_hit;
        rsp_alloc <= !lk_hit && vic_ok;
        rsp_way   <= lk_hit ? hit_way : (vic_ok ? vic : 2'd0);
        if (!lk_hit && vic_ok) begin
          state        <= S_FILL;
          fill_idx     <= lk_idx;
          fill_tag     <= lk_tag;
          fill_way     <= vic;
          rr_q[lk_idx] <= vic + 2'd1;
        end
      end
      if (inv_acc) begin
        case (inv_kind)
          2'b00: for (int w = 0; w < WAYS; w++)
                   if (iv_hitv[w]) vld_q[w][iv_idx] <= 1'b0;
          2'b01: vld_q[inv_way][inv_set] <= 1'b0;
          2'b10: begin
            state    <= S_WALK;
            walk_idx <= '0;
          end
          default: ;
        endcase
      end
      if (state == S_FILL && fill_done) begin
        vld_q[fill_way][fill_idx] <= 1'b1;
        state <= S_IDLE;
      end
      if (state == S_WALK) begin
        for (int w = 0; w < WAYS; w++) vld_q[w][walk_idx] <= 1'b0;
        walk_idx <= walk_idx + 1'b1;
        if (walk_idx == IDX_W'(SETS-1)) state <= S_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_FILL && fill_done)
      tag_q[fill_way][fill_idx] <= fill_tag;
  end
endmodule

// File: rtl/icache_tag_ctrl_chk.sv
module icache_tag_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lk_req,
  input logic       lk_ready,
  input logic       inv_req,
  input logic       inv_ready,
  input logic [3:0] lock_mask,
  input logic       rsp_valid,
  input logic       rsp_hit,
  input logic       rsp_alloc,
  input logic [1:0] rsp_way,
  input logic       busy
);
  p_resp_follows_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && lk_ready) |=> rsp_valid);

  p_no_resp_without_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_req && lk_ready) |=> !rsp_valid);

  p_fill_stalls_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_alloc) |-> (!lk_ready && !inv_ready));

  p_hit_alloc_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_hit && rsp_alloc));

  p_locked_never_victim_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_alloc) |-> ((($past(lock_mask)) >> rsp_way) & 4'b0001) == 4'b0000);

  p_all_locked_no_alloc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(lock_mask) == 4'b1111) |-> !rsp_alloc);

  p_walk_blocks_ports_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!lk_ready && !inv_ready));

  p_inv_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    inv_req |-> !lk_ready);
endmodule

bind icache_tag_ctrl icache_tag_ctrl_chk u_chk (.*);

// File: tb/tb_icache_tag_ctrl.sv
`timescale 1ns/1ps
module tb_icache_tag_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_req = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        lk_ready, rsp_valid, rsp_hit, rsp_alloc, inv_ready, busy;
  logic [1:0]  rsp_way;
  logic        fill_done = 1'b0;
  logic [3:0]  lock_mask = 4'b0000;
  logic        inv_req = 1'b0;
  logic [1:0]  inv_kind = 2'b11;
  logic [31:0] inv_addr = '0;
  logic [5:0]  inv_set = '0;
  logic [1:0]  inv_way = '0;

  always #10 clk = ~clk;

  icache_tag_ctrl dut (.*);

  int checks = 0;
  int errors = 0;

  bit          mv  [4][64];
  logic [20:0] mt  [4][64];
  logic [1:0]  mrr [64];

  logic [3:0] exp_q [$];
  string      req_q [$];

  logic [1:0]  pend_way;
  logic [5:0]  pend_set;
  logic [20:0] pend_tag;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int tg, input int st, input int off = 0);
    return {21'(tg), 6'(st), 5'(off)};
  endfunction

  function automatic int victim(input int s, input logic [3:0] lk);
    for (int w = 0; w < 4; w++)
      if (!mv[w][s] && !lk[w]) return w;
    for (int k = 0; k < 4; k++) begin
      int w;
      w = (int'(mrr[s]) + k) % 4;
      if (!lk[w]) return w;
    end
    return -1;
  endfunction

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 unexpected response", 1, 0);
      end else begin
        logic [3:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(rsp_hit == e[3], {r, " hit"}, rsp_hit, e[3]);
        check(rsp_alloc == e[2], {r, " alloc"}, rsp_alloc, e[2]);
        if (e[3] || e[2]) check(rsp_way == e[1:0], {r, " way"}, rsp_way, e[1:0]);
      end
    end
  end

  task automatic do_fill();
    repeat (2) @(negedge clk);
    check(lk_ready == 1'b0, "R2 lookup stalled during fill", lk_ready, 0);
    check(inv_ready == 1'b0, "R2 invalidate stalled during fill", inv_ready, 0);
    fill_done = 1'b1;
    @(negedge clk);
    fill_done = 1'b0;
    mv[pend_way][pend_set] = 1'b1;
    mt[pend_way][pend_set] = pend_tag;
  endtask

  task automatic lookup(input logic [31:0] a, input string rq, input bit autofill = 1'b1);
    int s, hw, v;
    logic [20:0] t;
    logic [3:0] e;
    @(negedge clk);
    lk_req = 1'b1;
    lk_addr = a;
    while (!lk_ready) @(negedge clk);
    s = int'(a[10:5]);
    t = a[31:11];
    hw = -1;
    for (int w = 0; w < 4; w++)
      if (hw < 0 && mv[w][s] && mt[w][s] == t) hw = w;
    if (hw >= 0) begin
      e = {1'b1, 1'b0, 2'(hw)};
      v = -1;
    end else begin
      v = victim(s, lock_mask);
      e = (v >= 0) ? {1'b0, 1'b1, 2'(v)} : 4'b0000;
      if (v >= 0) begin
        mrr[s] = 2'(v + 1);
        pend_way = 2'(v);
        pend_set = 6'(s);
        pend_tag = t;
      end
    end
    exp_q.push_back(e);
    req_q.push_back(rq);
    @(posedge clk);
    @(negedge clk);
    lk_req = 1'b0;
    if (v >= 0 && autofill) do_fill();
  endtask

  task automatic invalidate(input logic [1:0] k, input logic [31:0] a, input int st, input int wy);
    @(negedge clk);
    inv_req = 1'b1;
    inv_kind = k;
    inv_addr = a;
    inv_set = 6'(st);
    inv_way = 2'(wy);
    while (!inv_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    inv_req = 1'b0;
    if (k == 2'b00) begin
      for (int w = 0; w < 4; w++)
        if (mv[w][a[10:5]] && mt[w][a[10:5]] == a[31:11]) mv[w][a[10:5]] = 1'b0;
    end else if (k == 2'b01) begin
      mv[wy][st] = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int w = 0; w < 4; w++)
      for (int s = 0; s < 64; s++) mv[w][s] = 1'b0;
    for (int s = 0; s < 64; s++) mrr[s] = 2'd0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R11 busy after reset", busy, 0);
    check(rsp_valid == 1'b0, "R11 rsp_valid after reset", rsp_valid, 0);
    check(lk_ready == 1'b1, "R11 lk_ready after reset", lk_ready, 1);
    check(inv_ready == 1'b1, "R11 inv_ready after reset", inv_ready, 1);

    lookup(mk(1, 5, 3), "R11 R3 first miss");
    lookup(mk(1, 5, 28), "R1 hit offset ignored");
    lookup(mk(2, 5), "R3 second way");
    lookup(mk(3, 5), "R3 third way");
    lookup(mk(4, 5), "R3 fourth way");
    for (int i = 1; i <= 4; i++) lookup(mk(i, 5, i), "R1 hit full set");
    lookup(mk(5, 5), "R4 round robin from pointer");

    lock_mask = 4'b0010;
    lookup(mk(6, 5), "R5 R4 skip locked way");
    lookup(mk(2, 5), "R5 locked line still hits");

    lock_mask = 4'b1111;
    lookup(mk(7, 5), "R6 all locked no alloc");
    check(lk_ready == 1'b1, "R6 ready after unallocated miss", lk_ready, 1);
    lookup(mk(7, 5), "R6 still absent");
    lock_mask = 4'b0000;

    @(negedge clk);
    inv_req = 1'b1;
    inv_kind = 2'b11;
    lk_req = 1'b1;
    lk_addr = mk(2, 5);
    #1;
    check(lk_ready == 1'b0, "R12 invalidate wins", lk_ready, 0);
    check(inv_ready == 1'b1, "R12 invalidate accepted when idle", inv_ready, 1);
    @(negedge clk);
    inv_req = 1'b0;
    lk_req = 1'b0;
    for (int i = 2; i <= 6; i++) lookup(mk(i, 5), "R9 no-op kind leaves lines");

    invalidate(2'b00, mk(6, 5), 0, 0);
    lookup(mk(6, 5), "R7 R3 invalidated line refills lowest invalid");
    invalidate(2'b00, mk(99, 5), 0, 0);
    for (int i = 2; i <= 6; i++) lookup(mk(i, 5), "R7 absent address no effect");

    invalidate(2'b01, 32'h0, 5, 1);
    lookup(mk(2, 5), "R8 index invalidate then miss");
    lookup(mk(2, 5), "R8 refilled line hits");

    lookup(mk(8, 9), "R10 miss before lock change", 1'b0);
    lock_mask = 4'b1111;
    do_fill();
    lookup(mk(8, 9), "R10 fill kept assigned way");
    lock_mask = 4'b0000;

    for (int s = 0; s < 64; s++) lookup(mk(200 + s, s), "R1 sweep fill");
    for (int s = 0; s < 64; s++) lookup(mk(200 + s, s), "R1 sweep hit");

    @(negedge clk);
    inv_req = 1'b1;
    inv_kind = 2'b10;
    @(posedge clk);
    @(negedge clk);
    inv_req = 1'b0;
    check(lk_ready == 1'b0, "R9 lookup blocked during walk", lk_ready, 0);
    begin
      int cnt;
      cnt = 0;
      while (busy && cnt < 1000) begin
        cnt++;
        @(negedge clk);
      end
      check(cnt == 64, "R9 walk length", cnt, 64);
    end
    for (int w = 0; w < 4; w++)
      for (int s = 0; s < 64; s++) mv[w][s] = 1'b0;
    lookup(mk(200, 0), "R9 line gone after walk");
    lookup(mk(263, 63), "R9 last set cleared");
    lookup(mk(5, 5), "R9 set five cleared");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R1 all responses seen", exp_q.size(), 0);
    finish_run();
  end
endmodule